// File: doc/BRIEF.md
# Register ALU Execution Unit

This block computes the new destination value for one arithmetic instruction of a small 64-bit virtual-machine instruction set. It is purely combinational. It takes the four-bit operation code, the operand-select bit, a 32/64-bit mode flag, the 16-bit offset and 32-bit immediate fields, and the current destination and source register values. From these it produces the value to be written back, together with a flag that marks an encoding the unit does not support.

It covers the following operations: wrapping add, subtract and multiply; the bitwise or, and and xor; three kinds of shift; negation; plain and sign-extending moves; and byte-order conversion. In 32-bit mode the unit works on the low halves of the operands and clears the upper half of the result. The host byte order is a parameter (`HOST_BIG_ENDIAN`), so the same unit serves hosts of either order. When an encoding is flagged as illegal, the output simply equals the incoming destination value, which lets the surrounding pipeline write it back without any effect.

Top module: `vm_alu_exec`

## Requirements
- R1: The operation codes are add 0x0, sub 0x1, mul 0x2, or 0x4, and 0x5, lsh 0x6, rsh 0x7, neg 0x8, xor 0xA, mov 0xB, arsh 0xC and byte-order 0xD. The codes 0x3, 0x9, 0xE and 0xF raise `illegal`, and `result` then equals `dst_val`.
- R2: When `src_sel` is 1, the second operand is `src_val`. When it is 0, the second operand is `imm_field`, sign-extended from 32 to 64 bits in 64-bit mode and zero-extended in 32-bit mode.
- R3: In 32-bit mode (`wide`=0), every operation except byte-order reads only the low 32 bits of its operands and returns a result whose bits 63:32 are zero.
- R4: Add, sub, mul, or, and and xor give their plain results. Sums, differences and products wrap modulo 2^64 in 64-bit mode and modulo 2^32 in 32-bit mode.
- R5: The shift amount is the second operand ANDed with 0x3F in 64-bit mode and with 0x1F in 32-bit mode. Lsh and rsh fill with zeros. Arsh fills with the sign bit of the operand width (bit 63 in 64-bit mode, bit 31 in 32-bit mode).
- R6: Neg returns the two's-complement negation of the destination, and neither `src_val` nor `imm_field` has any effect on it.
- R7: Mov with offset 0 returns the second operand. Mov with offset 8, 16 or 32 returns the sign extension of that many low bits of the second operand. In 32-bit mode, offset 32 is illegal. Any other offset on a mov is also illegal.
- R8: Every operation other than mov with a nonzero offset is illegal, and `result` then equals `dst_val`.
- R9: Byte-order takes its width from `imm_field`, which must be 16, 32 or 64; any other value is illegal. The result holds the low width bits of the destination, either swapped or left as they are, zero-extended, and `src_val` has no effect. In 32-bit mode, width 64 yields a full 64-bit result.
- R10: In 32-bit mode, byte-order with `src_sel`=0 converts to little-endian, and with `src_sel`=1 it converts to big-endian. A conversion to the host's own order only truncates the value. A conversion to the other order reverses the bytes within the width.
- R11: In 64-bit mode, byte-order always reverses the bytes within the width, and `src_sel`=1 is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Operation code (opcode bits 7:4) |
| src_sel | input | 1 | Second operand select: 1 register, 0 immediate; byte-order direction in 32-bit mode |
| wide | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| off_field | input | 16 | Instruction offset field |
| imm_field | input | 32 | Instruction immediate field |
| dst_val | input | 64 | Current destination register value |
| src_val | input | 64 | Source register value |
| result | output | 64 | New destination value |
| illegal | output | 1 | Unsupported encoding; result equals dst_val |

## Verification
Two mechanisms can act on the same instruction in the same evaluation: the 32-bit mode rules, and the checks that decide whether an encoding is legal. A sign-extending move with offset 32 in 32-bit mode is the case where the two collide. The bench drives that move next to the same move in 64-bit mode. It expects the pass-through of the destination in the first case and the extended source in the second. Byte-order in 64-bit mode with `src_sel`=1 is handled in the same way: there the direction bit and the legality check overlap.

// File: rtl/vm_alu_pkg.sv
package vm_alu_pkg;
  localparam logic [3:0] OP_ADD  = 4'h0;
  localparam logic [3:0] OP_SUB  = 4'h1;
  localparam logic [3:0] OP_MUL  = 4'h2;
  localparam logic [3:0] OP_OR   = 4'h4;
  localparam logic [3:0] OP_AND  = 4'h5;
  localparam logic [3:0] OP_LSH  = 4'h6;
  localparam logic [3:0] OP_RSH  = 4'h7;
  localparam logic [3:0] OP_NEG  = 4'h8;
  localparam logic [3:0] OP_XOR  = 4'hA;
  localparam logic [3:0] OP_MOV  = 4'hB;
  localparam logic [3:0] OP_ARSH = 4'hC;
  localparam logic [3:0] OP_BORD = 4'hD;

  typedef enum logic [1:0] {
    SHK_LEFT  = 2'd0,
    SHK_RIGHT = 2'd1,
    SHK_ARITH = 2'd2
  } shift_kind_e;
endpackage

// File: rtl/vm_alu_opnd.sv
module vm_alu_opnd #(
  parameter int XLEN = 64
) (
  input  logic            wide,
  input  logic            src_sel,
  input  logic [31:0]     imm_field,
  input  logic [XLEN-1:0] dst_val,
  input  logic [XLEN-1:0] src_val,
  output logic [XLEN-1:0] a_op,
  output logic [XLEN-1:0] b_op
);
  localparam int HLEN = XLEN / 2;

  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] b_raw;

  always_comb begin
    if (wide) imm_ext = {{(XLEN-32){imm_field[31]}}, imm_field};
    else      imm_ext = {{(XLEN-32){1'b0}}, imm_field};
    b_raw = src_sel ? src_val : imm_ext;
    a_op  = wide ? dst_val : {{HLEN{1'b0}}, dst_val[HLEN-1:0]};
    b_op  = wide ? b_raw   : {{HLEN{1'b0}}, b_raw[HLEN-1:0]};
  end
endmodule

// File: rtl/vm_alu_shift.sv
module vm_alu_shift
  import vm_alu_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic            wide,
  input  shift_kind_e     kind,
  input  logic [XLEN-1:0] a_op,
  input  logic [SHW-1:0]  amt_raw,
  output logic [XLEN-1:0] sh_out
);
  localparam int HLEN = XLEN / 2;

  logic [SHW-1:0]  amt;
  logic [XLEN-1:0] a_sx;

  always_comb begin
    amt  = wide ? amt_raw : {1'b0, amt_raw[SHW-2:0]};
    a_sx = wide ? a_op : {{HLEN{a_op[HLEN-1]}}, a_op[HLEN-1:0]};
    unique case (kind)
      SHK_LEFT:  sh_out = a_op << amt;
      SHK_RIGHT: sh_out = a_op >> amt;
      default:   sh_out = $unsigned($signed(a_sx) >>> amt);
    endcase
  end
endmodule

// File: rtl/vm_alu_bswap.sv
module vm_alu_bswap #(
  parameter int XLEN            = 64,
  parameter bit HOST_BIG_ENDIAN = 1'b0
) (
  input  logic            wide,
  input  logic            src_sel,
  input  logic [31:0]     imm_field,
  input  logic [XLEN-1:0] dst_val,
  output logic [XLEN-1:0] bo_out,
  output logic            bo_bad
);
  localparam int NBYTES = XLEN / 8;

  logic [XLEN-1:0] sw16, sw32, sw64;
  logic            do_swap;
  logic            w16, w32, w64;

  genvar gi;
  generate
    for (gi = 0; gi < NBYTES; gi++) begin : g_full
      assign sw64[8*gi +: 8] = dst_val[8*(NBYTES-1-gi) +: 8];
    end
    for (gi = 0; gi < 4; gi++) begin : g_word
      assign sw32[8*gi +: 8] = dst_val[8*(3-gi) +: 8];
    end
    for (gi = 0; gi < 2; gi++) begin : g_half
      assign sw16[8*gi +: 8] = dst_val[8*(1-gi) +: 8];
    end
  endgenerate
  assign sw32[XLEN-1:32] = '0;
  assign sw16[XLEN-1:16] = '0;

  always_comb begin
    w16 = (imm_field == 32'd16);
    w32 = (imm_field == 32'd32);
    w64 = (imm_field == 32'd64);
    if (wide) do_swap = 1'b1;
    else      do_swap = src_sel ? !HOST_BIG_ENDIAN : HOST_BIG_ENDIAN;
    bo_bad = !(w16 || w32 || w64) || (wide && src_sel);
    if (w16)      bo_out = do_swap ? sw16 : {{(XLEN-16){1'b0}}, dst_val[15:0]};
    else if (w32) bo_out = do_swap ? sw32 : {{(XLEN-32){1'b0}}, dst_val[31:0]};
    else          bo_out = do_swap ? sw64 : dst_val;
  end
endmodule

// File: rtl/vm_alu_exec.sv
module vm_alu_exec
  import vm_alu_pkg::*;
#(
  parameter int XLEN            = 64,
  parameter bit HOST_BIG_ENDIAN = 1'b0
) (
  input  logic [3:0]      op_code,
  input  logic            src_sel,
  input  logic            wide,
  input  logic [15:0]     off_field,
  input  logic [31:0]     imm_field,
  input  logic [XLEN-1:0] dst_val,
  input  logic [XLEN-1:0] src_val,
  output logic [XLEN-1:0] result,
  output logic            illegal
);
  localparam int HLEN = XLEN / 2;
  localparam int SHW  = $clog2(XLEN);

  logic [XLEN-1:0] a_op, b_op, sh_out, bo_out, res_pre, mov_val;
  logic            bo_bad, code_bad, off_bad;
  shift_kind_e     kind;

  vm_alu_opnd #(.XLEN(XLEN)) u_opnd (
    .wide(wide), .src_sel(src_sel), .imm_field(imm_field),
    .dst_val(dst_val), .src_val(src_val), .a_op(a_op), .b_op(b_op)
  );

  always_comb begin
    unique case (op_code)
      OP_RSH:  kind = SHK_RIGHT;
      OP_ARSH: kind = SHK_ARITH;
      default: kind = SHK_LEFT;
    endcase
  end

  vm_alu_shift #(.XLEN(XLEN)) u_shift (
    .wide(wide), .kind(kind), .a_op(a_op), .amt_raw(b_op[SHW-1:0]), .sh_out(sh_out)
  );

  vm_alu_bswap #(.XLEN(XLEN), .HOST_BIG_ENDIAN(HOST_BIG_ENDIAN)) u_bswap (
    .wide(wide), .src_sel(src_sel), .imm_field(imm_field),
    .dst_val(dst_val), .bo_out(bo_out), .bo_bad(bo_bad)
  );

  always_comb begin
    unique case (off_field)
      16'd8:   mov_val = {{(XLEN-8){b_op[7]}}, b_op[7:0]};
      16'd16:  mov_val = {{(XLEN-16){b_op[15]}}, b_op[15:0]};
      16'd32:  mov_val = {{(XLEN-32){b_op[31]}}, b_op[31:0]};
      default: mov_val = b_op;
    endcase
  end

  always_comb begin
    code_bad = 1'b0;
    res_pre  = dst_val;
    unique case (op_code)
      OP_ADD:  res_pre = a_op + b_op;
      OP_SUB:  res_pre = a_op - b_op;
      OP_MUL:  res_pre = a_op * b_op;
      OP_OR:   res_pre = a_op | b_op;
      OP_AND:  res_pre = a_op & b_op;
      OP_XOR:  res_pre = a_op ^ b_op;
      OP_LSH, OP_RSH, OP_ARSH: res_pre = sh_out;
      OP_NEG:  res_pre = '0 - a_op;
      OP_MOV:  res_pre = mov_val;
      OP_BORD: res_pre = bo_out;
      default: code_bad = 1'b1;
    endcase
    if (!wide && op_code != OP_BORD) res_pre[XLEN-1:HLEN] = '0;

    if (op_code == OP_MOV)
      off_bad = !(off_field == 16'd0 || off_field == 16'd8 || off_field == 16'd16
                  || (off_field == 16'd32 && wide));
    else
      off_bad = (off_field != 16'd0);

    illegal = code_bad || off_bad || (op_code == OP_BORD && bo_bad);
    result  = illegal ? dst_val : res_pre;
  end
endmodule

// File: rtl/vm_alu_exec_chk.sv
module vm_alu_exec_chk #(
  parameter int XLEN = 64
) (
  input logic [3:0]      op_code,
  input logic            src_sel,
  input logic            wide,
  input logic [15:0]     off_field,
  input logic [31:0]     imm_field,
  input logic [XLEN-1:0] dst_val,
  input logic [XLEN-1:0] src_val,
  input logic [XLEN-1:0] result,
  input logic            illegal
);
  localparam int HLEN = XLEN / 2;

  always_comb begin
    // R1 R8: a flagged encoding passes the destination through
    if (illegal)
      a_r1_illegal_keeps_dst: assert (result == dst_val)
        else $error("illegal encoding changed destination");
    // R3: 32-bit mode clears the upper half except for byte-order
    if (!illegal && !wide && op_code != 4'hD)
      a_r3_upper_cleared: assert (result[XLEN-1:HLEN] == '0)
        else $error("upper half not cleared in 32-bit mode");
    // R6: negation in 64-bit mode
    if (!illegal && wide && op_code == 4'h8)
      a_r6_neg_value: assert (result + dst_val == '0)
        else $error("negation mismatch");
    // R7: plain register move in 64-bit mode
    if (!illegal && wide && src_sel && op_code == 4'hB && off_field == 16'd0)
      a_r7_plain_move: assert (result == src_val)
        else $error("plain move mismatch");
    // R9: a 16-bit byte-order result fits in 16 bits
    if (!illegal && op_code == 4'hD && imm_field == 32'd16)
      a_r9_bord16_width: assert (result[XLEN-1:16] == '0)
        else $error("16-bit byte-order result too wide");
  end
endmodule

bind vm_alu_exec vm_alu_exec_chk #(.XLEN(XLEN)) u_chk (
  .op_code(op_code), .src_sel(src_sel), .wide(wide), .off_field(off_field),
  .imm_field(imm_field), .dst_val(dst_val), .src_val(src_val),
  .result(result), .illegal(illegal)
);

// File: tb/sim_vm_alu_exec.sv
module sim_vm_alu_exec;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_code = '0;
  logic        src_sel = 1'b0;
  logic        wide = 1'b0;
  logic [15:0] off_field = '0;
  logic [31:0] imm_field = '0;
  logic [63:0] dst_val = '0;
  logic [63:0] src_val = '0;
  logic [63:0] result;
  logic        illegal;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vm_alu_exec u0 (
    .op_code(op_code), .src_sel(src_sel), .wide(wide), .off_field(off_field),
    .imm_field(imm_field), .dst_val(dst_val), .src_val(src_val),
    .result(result), .illegal(illegal)
  );

  task automatic apply(input logic [3:0] op, input logic sel, input logic w,
                       input logic [15:0] off, input logic [31:0] imm,
                       input logic [63:0] d, input logic [63:0] s);
    op_code = op; src_sel = sel; wide = w; off_field = off;
    imm_field = imm; dst_val = d; src_val = s;
    #(CLK_PERIOD/2);
  endtask

  task automatic chk(input string req, input logic [63:0] exp_res, input logic exp_ill);
    n_run++;
    if (result !== exp_res || illegal !== exp_ill) begin
      n_fail++;
      $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
               req, result, illegal, exp_res, exp_ill);
    end
  endtask

  task automatic t_reset_state();
    apply(4'h0, 1'b0, 1'b0, 16'h0, 32'h0, 64'h0, 64'h0);
    chk("R3 reset-state idle add", 64'h0, 1'b0);
  endtask

  task automatic t_arith();
    apply(4'h0, 1, 1, 0, 0, 64'd5, 64'd3);                 chk("R4 add", 64'd8, 0);
    apply(4'h1, 1, 1, 0, 0, 64'd0, 64'd1);                 chk("R4 sub wrap", '1, 0);
    apply(4'h2, 1, 1, 0, 0, 64'h1_0000_0000, 64'h1_0000_0000); chk("R4 mul wrap", 64'h0, 0);
    apply(4'hA, 0, 1, 0, 32'h00FF, 64'hFFFF, 64'h0);       chk("R4 xor imm", 64'hFF00, 0);
    apply(4'h5, 1, 1, 0, 0, 64'hF0F0, 64'h0FF0);           chk("R4 and", 64'h00F0, 0);
  endtask

  task automatic t_operand_sel();
    apply(4'h0, 0, 1, 0, 32'hFFFF_FFFF, 64'd1, 64'd77);    chk("R2 imm sign-extended", 64'h0, 0);
    apply(4'hB, 0, 1, 0, 32'h8000_0000, 64'h0, 64'd9);     chk("R2 mov imm 64", 64'hFFFF_FFFF_8000_0000, 0);
    apply(4'hB, 0, 0, 0, 32'h8000_0000, 64'h0, 64'd9);     chk("R2 mov imm 32", 64'h0000_0000_8000_0000, 0);
  endtask

  task automatic t_narrow();
    apply(4'h0, 1, 0, 0, 0, 64'hAAAA_AAAA_FFFF_FFFF, 64'd1); chk("R3 add wrap 32", 64'h0, 0);
    apply(4'h4, 1, 0, 0, 0, 64'h1234_5678_0000_0001, 64'hFFFF_0000_0000_0002); chk("R3 or low half", 64'h3, 0);
  endtask

  task automatic t_shift();
    apply(4'h6, 1, 1, 0, 0, 64'd1, 64'd65);                chk("R5 lsh mask 64", 64'd2, 0);
    apply(4'h6, 1, 0, 0, 0, 64'd1, 64'd33);                chk("R5 lsh mask 32", 64'd2, 0);
    apply(4'h6, 1, 0, 0, 0, 64'd1, 64'd31);                chk("R5 lsh 31", 64'h8000_0000, 0);
    apply(4'h7, 1, 1, 0, 0, 64'h8000_0000_0000_0000, 64'd63); chk("R5 rsh 64", 64'd1, 0);
    apply(4'hC, 1, 1, 0, 0, 64'h8000_0000_0000_0000, 64'd63); chk("R5 arsh 64", '1, 0);
    apply(4'hC, 1, 0, 0, 0, 64'h0000_0000_8000_0000, 64'd4);  chk("R5 arsh 32", 64'hF800_0000, 0);
    apply(4'h7, 1, 0, 0, 0, 64'hFFFF_FFFF_8000_0000, 64'd4);  chk("R5 rsh 32", 64'h0800_0000, 0);
  endtask

  task automatic t_neg();
    apply(4'h8, 1, 1, 0, 0, 64'd1, 64'd123);               chk("R6 neg 64 ignores src", '1, 0);
    apply(4'h8, 0, 1, 0, 32'h55, 64'd1, 64'd0);            chk("R6 neg 64 ignores imm", '1, 0);
    apply(4'h8, 1, 0, 0, 0, 64'd1, 64'd5);                 chk("R6 neg 32", 64'hFFFF_FFFF, 0);
  endtask

  task automatic t_movsx();
    apply(4'hB, 1, 1, 16'd8, 0, 64'h0, 64'h80);            chk("R7 movsx 8", 64'hFFFF_FFFF_FFFF_FF80, 0);
    apply(4'hB, 1, 1, 16'd16, 0, 64'h0, 64'h1234_8001);    chk("R7 movsx 16", 64'hFFFF_FFFF_FFFF_8001, 0);
    apply(4'hB, 1, 1, 16'd32, 0, 64'h0, 64'h7FFF_FFFF);    chk("R7 movsx 32 pos", 64'h7FFF_FFFF, 0);
    apply(4'hB, 1, 0, 16'd16, 0, 64'h0, 64'hFFFF);         chk("R7 movsx 16 narrow", 64'hFFFF_FFFF, 0);
    apply(4'hB, 1, 0, 16'd32, 0, 64'hDEAD, 64'h8000_0000); chk("R7 movsx 32 narrow illegal", 64'hDEAD, 1);
    apply(4'hB, 1, 1, 16'd32, 0, 64'hDEAD, 64'h8000_0000); chk("R7 movsx 32 wide", 64'hFFFF_FFFF_8000_0000, 0);
    apply(4'hB, 1, 1, 16'd4, 0, 64'hBEEF, 64'h1);          chk("R7 bad offset", 64'hBEEF, 1);
  endtask

  task automatic t_illegal();
    apply(4'h0, 1, 1, 16'd1, 0, 64'h1111, 64'd1);          chk("R8 offset on add", 64'h1111, 1);
    for (int i = 0; i < 4; i++) begin
      logic [3:0] bad;
      bad = (i == 0) ? 4'h3 : (i == 1) ? 4'h9 : (i == 2) ? 4'hE : 4'hF;
      apply(bad, 1, 1, 0, 0, 64'h2222, 64'd7);             chk("R1 unsupported code", 64'h2222, 1);
    end
  endtask

  task automatic t_bord();
    logic [63:0] d;
    d = 64'h1122_3344_5566_7788;
    apply(4'hD, 0, 1, 0, 32'd16, d, 64'h0);                chk("R11 swap 16", 64'h8877, 0);
    apply(4'hD, 0, 1, 0, 32'd32, d, 64'h0);                chk("R11 swap 32", 64'h8877_6655, 0);
    apply(4'hD, 0, 1, 0, 32'd64, d, 64'hFFFF);             chk("R9 swap 64 ignores src", 64'h8877_6655_4433_2211, 0);
    apply(4'hD, 0, 1, 0, 32'd8, d, 64'h0);                 chk("R9 bad width", d, 1);
    apply(4'hD, 1, 1, 0, 32'd16, d, 64'h0);                chk("R11 reserved select", d, 1);
    apply(4'hD, 0, 0, 0, 32'd16, d, 64'h0);                chk("R10 to host order 16", 64'h7788, 0);
    apply(4'hD, 0, 0, 0, 32'd32, d, 64'h0);                chk("R10 to host order 32", 64'h5566_7788, 0);
    apply(4'hD, 1, 0, 0, 32'd16, d, 64'h0);                chk("R10 to foreign order 16", 64'h8877, 0);
    apply(4'hD, 1, 0, 0, 32'd64, d, 64'h0);                chk("R10 foreign order 64", 64'h8877_6655_4433_2211, 0);
  endtask

  initial begin : wdog
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000 && !done) begin
        n_run++; n_fail++;
        $display("FAIL watchdog: result=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_arith();
    t_operand_sel();
    t_narrow();
    t_shift();
    t_neg();
    t_movsx();
    t_illegal();
    t_bord();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule